// File: doc/BRIEF.md
# Paddle-Zone Vertical Velocity Encoder

This block decides how fast, and in which vertical direction, the ball moves after it meets a paddle, and it moves the ball's vertical position by that amount once per video frame. When a ball/paddle coincidence strobe arrives, the block picks the struck paddle's top line from the side flag. It takes the difference between the current line counter and that top line. It then decides which of eight equal line bands of the paddle was struck and converts that band into a signed velocity code. Bands nearer the paddle ends give larger vertical speeds. The upper half of the paddle sends the ball up and the lower half sends it down.

The ball can drift into vertical blanking at the top or bottom of the screen. To handle this, a small guard state machine registers the coincidence of the ball's vertical window with blanking. It reverses the vertical direction exactly once per such episode, so the ball cannot oscillate and stay trapped in blanking. The same 4-bit code drives a hex diagnostic output. On each rising edge of vertical sync the ball row is stepped by the signed velocity.

The guard machine has two states. GUARD_FREE takes the transition "arm" to GUARD_HELD when the registered coincidence is high, and that transition issues the single reversal pulse. GUARD_HELD takes the transition "release" back to GUARD_FREE when the registered coincidence drops. Otherwise each state stays where it is ("idle" in GUARD_FREE, "hold" in GUARD_HELD).

Top module: `ball_vert_steer`

## Requirements
- R1: A synchronous reset sets the velocity code to 0000, the ball row to the start value (240 by default) and the step pulse to 0.
- R2: With the default 16-line paddle, each band is 2 lines. A strike in upper bands 0, 1, 2 or 3 (counted from the paddle's top line) yields up-3, up-2, up-1 and zero, which are codes 1011, 1010, 1001 and 0000.
- R3: A strike in lower bands 4, 5, 6 or 7 yields zero, down-1, down-2 and down-3, which are codes 0000, 0001, 0010 and 0011.
- R4: Code bit 3 is the direction (1 = up, toward smaller line numbers) and bits 2:0 are the magnitude. The zero velocity is always 0000, never 1000.
- R5: A strobe is registered on the clock edge that samples it, so the new code is visible one cycle later. Without a strobe the code is unchanged, and a strobe whose line lies outside the struck paddle's 16 lines is ignored.
- R6: The band is measured only against the paddle selected by the side flag (0 = left, 1 = right). The other paddle's position has no effect.
- R7: When the ball window and vertical blanking are both high in a cycle, the direction bit of a non-zero code inverts two clock edges later with the magnitude kept. A zero code stays 0000.
- R8: Coincidence that lasts any number of cycles reverses the direction only once. A further reversal needs the coincidence to go low for at least one cycle and then return.
- R9: If a valid strobe and a reversal fall on the same clock edge, the strobe's code is loaded and the reversal is dropped.
- R10: On the first cycle of each vsync high level, the ball row moves by the code in force before that edge (up subtracts, down adds), wrapping modulo 512. The step pulse is high for that one cycle, and at no other time does the row change.
- R11: The diagnostic hex output always equals the velocity code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| line_cnt | input | 9 | Current video line |
| paddle_top_l | input | 9 | Top line of the left paddle |
| paddle_top_r | input | 9 | Top line of the right paddle |
| hit_strobe | input | 1 | Ball/paddle coincidence strobe |
| hit_right | input | 1 | Side of the struck paddle: 0 left, 1 right |
| vblank | input | 1 | Vertical blanking |
| ball_win | input | 1 | Ball's vertical video window |
| vsync | input | 1 | Vertical sync level |
| vel_code | output | 4 | Direction bit plus 3-bit speed |
| diag_hex | output | 4 | Copy of the code for a hex display |
| ball_y | output | 9 | Ball vertical position |
| step_pulse | output | 1 | One-cycle pulse when the row has been stepped |

## Verification
The assertions watch every cycle for four things. The zero code must stay canonical. The code may change only on a valid strike or a reversal pulse. A reversal pulse must keep the magnitude and invert only a non-zero direction. The ball row may move only on a step pulse, and that pulse may never last two cycles.

The mapping from strike line to band, the choice of paddle by side, the once-only reversal during long blanking coincidence, the priority of a strike over a reversal, and the wrap of the row at the screen edge depend on stimulus sequences. Only the bench scenarios show them, compared cycle by cycle against an integer model.

// File: rtl/vse_pkg.sv
package vse_pkg;

    localparam int MAG_W = 3;

    typedef enum logic [0:0] {
        GUARD_FREE = 1'b0,
        GUARD_HELD = 1'b1
    } guard_state_t;

    typedef struct packed {
        logic             up;
        logic [MAG_W-1:0] mag;
    } vcode_t;

    localparam vcode_t VCODE_ZERO = '{up: 1'b0, mag: '0};

    // Upper four bands run from fastest-up to still, lower four from still to fastest-down.
    function automatic vcode_t band_to_code(input logic [2:0] band);
        vcode_t c;
        c.mag = {1'b0, (band[2] ? band[1:0] : ~band[1:0])};
        c.up  = !band[2] && (band[1:0] != 2'b11);
        return c;
    endfunction

    function automatic vcode_t reverse_code(input vcode_t v);
        vcode_t c;
        c.mag = v.mag;
        c.up  = (v.mag != '0) ? !v.up : 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/vse_band_decode.sv
module vse_band_decode
    import vse_pkg::*;
#(
    parameter int COORD_W   = 9,
    parameter int PAD_LINES = 16
) (
    input  logic [COORD_W-1:0] line_cnt,
    input  logic [COORD_W-1:0] top_left,
    input  logic [COORD_W-1:0] top_right,
    input  logic               side_right,
    input  logic               strobe,
    output logic               hit_valid,
    output vcode_t             hit_code
);

    localparam int BAND_SHIFT = $clog2(PAD_LINES / 8);

    logic [COORD_W-1:0] top_sel;
    logic [COORD_W-1:0] offset;
    logic               in_range;

    always_comb begin
        top_sel   = side_right ? top_right : top_left;
        offset    = line_cnt - top_sel;
        in_range  = offset < COORD_W'(PAD_LINES);
        hit_valid = strobe && in_range;
        hit_code  = band_to_code(offset[BAND_SHIFT +: 3]);
    end

endmodule

// File: rtl/vse_edge_guard.sv
module vse_edge_guard
    import vse_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ball_win,
    input  logic vblank,
    output logic flip
);

    guard_state_t state, state_nx;
    logic         coin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= GUARD_FREE;
            coin_q <= 1'b0;
        end else begin
            state  <= state_nx;
            coin_q <= ball_win && vblank;
        end
    end

    always_comb begin
        state_nx = state;
        flip     = 1'b0;
        unique case (state)
            GUARD_FREE: begin
                if (coin_q) begin
                    state_nx = GUARD_HELD;
                    flip     = 1'b1;
                end
            end
            GUARD_HELD: begin
                if (!coin_q) state_nx = GUARD_FREE;
            end
        endcase
    end

    // R8: a reversal never repeats on the following cycle
    p_single_flip_r8: assert property (@(posedge clk) disable iff (rst)
        flip |=> !flip);

endmodule

// File: rtl/vse_vpos.sv
module vse_vpos
    import vse_pkg::*;
#(
    parameter int COORD_W = 9,
    parameter int Y_START = 240
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vsync,
    input  vcode_t             vel,
    output logic [COORD_W-1:0] ball_y,
    output logic               step_pulse
);

    logic               vsync_q;
    logic               frame_edge;
    logic [COORD_W-1:0] step_amt;

    always_comb begin
        frame_edge = vsync && !vsync_q;
        step_amt   = COORD_W'(vel.mag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vsync_q    <= 1'b0;
            ball_y     <= COORD_W'(Y_START);
            step_pulse <= 1'b0;
        end else begin
            vsync_q    <= vsync;
            step_pulse <= frame_edge;
            if (frame_edge)
                ball_y <= vel.up ? (ball_y - step_amt) : (ball_y + step_amt);
        end
    end

    // R10: the row only moves together with a step pulse
    p_row_still_r10: assert property (@(posedge clk) disable iff (rst)
        !step_pulse |-> (ball_y == $past(ball_y)));

    // R10: step pulse lasts exactly one cycle
    p_step_single_r10: assert property (@(posedge clk) disable iff (rst)
        step_pulse |=> !step_pulse);

endmodule

// File: rtl/ball_vert_steer.sv
module ball_vert_steer
    import vse_pkg::*;
#(
    parameter int COORD_W   = 9,
    parameter int PAD_LINES = 16,
    parameter int Y_START   = 240
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] line_cnt,
    input  logic [COORD_W-1:0] paddle_top_l,
    input  logic [COORD_W-1:0] paddle_top_r,
    input  logic               hit_strobe,
    input  logic               hit_right,
    input  logic               vblank,
    input  logic               ball_win,
    input  logic               vsync,
    output logic [3:0]         vel_code,
    output logic [3:0]         diag_hex,
    output logic [COORD_W-1:0] ball_y,
    output logic               step_pulse
);

    logic   hit_valid;
    vcode_t hit_code;
    logic   flip;
    vcode_t vel_q;

    vse_band_decode #(
        .COORD_W   (COORD_W),
        .PAD_LINES (PAD_LINES)
    ) u_decode (
        .line_cnt   (line_cnt),
        .top_left   (paddle_top_l),
        .top_right  (paddle_top_r),
        .side_right (hit_right),
        .strobe     (hit_strobe),
        .hit_valid  (hit_valid),
        .hit_code   (hit_code)
    );

    vse_edge_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .ball_win (ball_win),
        .vblank   (vblank),
        .flip     (flip)
    );

    always_ff @(posedge clk) begin
        if (rst)            vel_q <= VCODE_ZERO;
        else if (hit_valid) vel_q <= hit_code;
        else if (flip)      vel_q <= reverse_code(vel_q);
    end

    vse_vpos #(
        .COORD_W (COORD_W),
        .Y_START (Y_START)
    ) u_vpos (
        .clk        (clk),
        .rst        (rst),
        .vsync      (vsync),
        .vel        (vel_q),
        .ball_y     (ball_y),
        .step_pulse (step_pulse)
    );

    always_comb begin
        vel_code = vel_q;
        diag_hex = vel_q;
    end

    // R4: zero speed never carries the up flag
    p_zero_canonical_r4: assert property (@(posedge clk) disable iff (rst)
        (vel_code[2:0] == 3'd0) |-> !vel_code[3]);

    // R5: a valid strike lands on the next cycle
    p_strike_loads_r5: assert property (@(posedge clk) disable iff (rst)
        hit_valid |=> (vel_code == $past(hit_code)));

    // R5: no strike and no reversal means no change
    p_code_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (!hit_valid && !flip) |=> $stable(vel_code));

    // R7: reversal keeps speed and inverts a non-zero direction
    p_reverse_r7: assert property (@(posedge clk) disable iff (rst)
        (flip && !hit_valid) |=> ((vel_code[2:0] == $past(vel_code[2:0])) &&
                                  ((vel_code[2:0] == 3'd0) || (vel_code[3] != $past(vel_code[3])))));

endmodule

// File: tb/ball_vert_steer_test.sv
module ball_vert_steer_test;

    localparam int W    = 9;
    localparam int PAD  = 16;
    localparam int BH   = PAD / 8;
    localparam int Y0   = 240;
    localparam int MODV = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] line_cnt = '0;
    logic [W-1:0] paddle_top_l = '0;
    logic [W-1:0] paddle_top_r = '0;
    logic         hit_strobe = 1'b0;
    logic         hit_right = 1'b0;
    logic         vblank = 1'b0;
    logic         ball_win = 1'b0;
    logic         vsync = 1'b0;
    logic [3:0]   vel_code;
    logic [3:0]   diag_hex;
    logic [W-1:0] ball_y;
    logic         step_pulse;

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R1";

    ball_vert_steer #(.COORD_W(W), .PAD_LINES(PAD), .Y_START(Y0)) uut (
        .clk(clk), .rst(rst), .line_cnt(line_cnt),
        .paddle_top_l(paddle_top_l), .paddle_top_r(paddle_top_r),
        .hit_strobe(hit_strobe), .hit_right(hit_right),
        .vblank(vblank), .ball_win(ball_win), .vsync(vsync),
        .vel_code(vel_code), .diag_hex(diag_hex),
        .ball_y(ball_y), .step_pulse(step_pulse)
    );

    always #4 clk = ~clk;

    // Behavioural reference: velocity as a signed integer, negative = up.
    int m_vel = 0;
    int m_y = Y0;
    bit m_step = 0;
    bit m_coin = 0;
    bit m_prev_coin = 0;
    bit m_vs = 0;

    function automatic int band_vel(int b);
        return (b < 4) ? -(3 - b) : (b - 4);
    endfunction

    function automatic int code_of(int v);
        return (v < 0) ? (8 + (-v)) : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_vel = 0; m_y = Y0; m_step = 0;
            m_coin = 0; m_prev_coin = 0; m_vs = 0;
        end else begin
            int nv;
            int off;
            nv  = m_vel;
            off = int'(line_cnt) - (hit_right ? int'(paddle_top_r) : int'(paddle_top_l));
            if (hit_strobe && off >= 0 && off < PAD) nv = band_vel(off / BH);
            else if (m_coin && !m_prev_coin) nv = -m_vel;
            if (vsync && !m_vs) begin
                m_y = ((m_y + m_vel) % MODV + MODV) % MODV;
                m_step = 1;
            end else begin
                m_step = 0;
            end
            m_prev_coin = m_coin;
            m_coin = ball_win && vblank;
            m_vs = vsync;
            m_vel = nv;
        end
    end

    task automatic chk(string t, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(tag, int'(vel_code), code_of(m_vel));
        chk("R11", int'(diag_hex), code_of(m_vel));
        chk(tag, int'(ball_y), m_y);
        chk(tag, int'(step_pulse), int'(m_step));
    endtask

    task automatic strike(bit side, int top, int band);
        hit_right  = side;
        line_cnt   = W'(top + band * BH + (band % 2));
        hit_strobe = 1'b1;
        tick();
        hit_strobe = 1'b0;
    endtask

    task automatic coincide(int cycles);
        ball_win = 1'b1; vblank = 1'b1;
        for (int i = 0; i < cycles; i++) tick();
        ball_win = 1'b0; vblank = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int y_exp;
        @(negedge clk);
        paddle_top_l = W'(100);
        paddle_top_r = W'(300);
        // R1 reset state
        tag = "R1";
        for (int i = 0; i < 4; i++) tick();
        rst = 1'b0;
        tick();
        chk("R1", int'(vel_code), 0);
        chk("R1", int'(ball_y), Y0);
        chk("R1", int'(step_pulse), 0);

        // R2 upper bands, R4 encoding
        tag = "R2";
        strike(1'b0, 100, 0); chk("R2", int'(vel_code), 4'b1011);
        strike(1'b0, 100, 1); chk("R2", int'(vel_code), 4'b1010);
        strike(1'b0, 100, 2); chk("R2", int'(vel_code), 4'b1001);
        strike(1'b0, 100, 3); chk("R4", int'(vel_code), 4'b0000);

        // R3 lower bands
        tag = "R3";
        strike(1'b0, 100, 4); chk("R3", int'(vel_code), 4'b0000);
        strike(1'b0, 100, 5); chk("R3", int'(vel_code), 4'b0001);
        strike(1'b0, 100, 6); chk("R3", int'(vel_code), 4'b0010);
        strike(1'b0, 100, 7); chk("R3", int'(vel_code), 4'b0011);

        // R5 hold and out-of-paddle strikes
        tag = "R5";
        for (int i = 0; i < 3; i++) tick();
        chk("R5", int'(vel_code), 4'b0011);
        hit_right = 1'b0; line_cnt = W'(99); hit_strobe = 1'b1; tick();
        line_cnt = W'(116); tick(); hit_strobe = 1'b0;
        chk("R5", int'(vel_code), 4'b0011);

        // R6 struck paddle only
        tag = "R6";
        paddle_top_r = W'(200);
        strike(1'b1, 200, 0); chk("R6", int'(vel_code), 4'b1011);
        hit_right = 1'b1; line_cnt = W'(107); hit_strobe = 1'b1; tick(); hit_strobe = 1'b0;
        chk("R6", int'(vel_code), 4'b1011);
        paddle_top_l = W'(214);
        strike(1'b1, 200, 7); chk("R6", int'(vel_code), 4'b0011);
        paddle_top_l = W'(100);

        // R7 single-cycle coincidence, two-edge latency
        tag = "R7";
        strike(1'b0, 100, 6);
        coincide(1);
        chk("R7", int'(vel_code), 4'b0010);
        tick();
        chk("R7", int'(vel_code), 4'b1010);
        ball_win = 1'b1; tick(); tick(); ball_win = 1'b0;
        chk("R7", int'(vel_code), 4'b1010);
        strike(1'b0, 100, 3);
        coincide(1); tick(); tick();
        chk("R7", int'(vel_code), 4'b0000);

        // R8 long coincidence reverses once
        tag = "R8";
        strike(1'b0, 100, 7);
        coincide(10);
        chk("R8", int'(vel_code), 4'b1011);
        tick(); tick();
        chk("R8", int'(vel_code), 4'b1011);
        coincide(3); tick();
        chk("R8", int'(vel_code), 4'b0011);

        // R9 strike beats reversal on the same edge
        tag = "R9";
        strike(1'b0, 100, 7);
        ball_win = 1'b1; vblank = 1'b1; tick();
        ball_win = 1'b0; vblank = 1'b0;
        strike(1'b0, 100, 5);
        chk("R9", int'(vel_code), 4'b0001);
        tick(); tick();
        chk("R9", int'(vel_code), 4'b0001);

        // R10 frame stepping
        tag = "R10";
        strike(1'b0, 100, 2);
        y_exp = int'(ball_y);
        vsync = 1'b1; tick();
        chk("R10", int'(step_pulse), 1);
        chk("R10", int'(ball_y), y_exp - 1);
        tick(); tick();
        chk("R10", int'(step_pulse), 0);
        chk("R10", int'(ball_y), y_exp - 1);
        vsync = 1'b0; tick();
        strike(1'b0, 100, 0);
        y_exp = int'(ball_y);
        for (int f = 0; f < 90; f++) begin
            vsync = 1'b1; tick();
            vsync = 1'b0; tick();
            y_exp = (y_exp - 3 + MODV) % MODV;
        end
        chk("R10", int'(ball_y), y_exp);
        strike(1'b1, 200, 6);
        for (int f = 0; f < 4; f++) begin
            vsync = 1'b1; tick(); tick();
            vsync = 1'b0; tick();
            y_exp = (y_exp + 2) % MODV;
        end
        chk("R10", int'(ball_y), y_exp);

        // R1 reset again mid-run
        tag = "R1";
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        chk("R1", int'(vel_code), 0);
        chk("R1", int'(ball_y), Y0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule